// File: doc/BRIEF.md
# Pin Fault Sample Window Counter

This block measures how often one chosen display pin reads as asserted during a fixed observation window. A controller picks a pin by index, says whether it is a backplane or a frontplane pin, picks a sample-clock division and a window length, and pulses a start strobe. The block then samples the selected pin once per sample-clock tick, counts the asserted samples in an 8-bit saturating counter, and raises a sticky completion flag when the window closes.

The sample clock is derived from the bus clock by a power-of-two divider chosen by a 3-bit code. The window is a power-of-two number of sample ticks, at least four, chosen by another 3-bit code. A final count of 255 tells software that the true number may have been larger. The completion flag stays set until a clear strobe or a new start removes it, and an interrupt output follows it while interrupts are enabled.

Top module: `fdet_sample_window`

## Requirements
- R1: With prescaler code k (0 to 7), a sample tick occurs on every 2^k-th clock of a run: the run's clock cycles are numbered 1, 2, ... starting after the clock edge that accepts the start, and the pin is sampled at the end of each cycle whose number is a multiple of 2^k.
- R2: With window code w (0 to 7), a run lasts 4·2^w sample ticks, so the completion flag rises at the clock edge ending run cycle 4·2^w·2^k; no completion flag is set while a run is in progress.
- R3: The count equals the number of sample ticks at which the selected pin was 1, never changes by more than one per clock, and stops at 255 instead of wrapping.
- R4: The selected pin is `bp_pins_i[pin_idx]` when the backplane select is 1 and `fp_pins_i[pin_idx]` when it is 0; no other pin affects the count.
- R5: A start strobe while idle clears the count and the completion flag at that edge and begins a run, also when a previous result is still flagged.
- R6: A start strobe during a run is ignored, and the pin index, plane select and both codes are taken only at the accepted start; later changes have no effect on the running measurement.
- R7: The completion flag is sticky and is cleared by a one-cycle clear strobe; when the clear strobe and window completion fall on the same edge, the flag is set.
- R8: The interrupt output is 1 exactly when the completion flag is 1 and the interrupt enable input is 1.
- R9: After completion the count holds its final value, including across a clear of the flag, until the next accepted start.
- R10: After reset the count is 0 and the completion flag and interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only while idle |
| pin_idx_i | input | 6 | Index of the pin to measure |
| bp_sel_i | input | 1 | 1 selects the backplane pin group, 0 the frontplane group |
| presc_code_i | input | 3 | Sample clock division code, divide by 2^code |
| win_code_i | input | 3 | Window length code, 4·2^code sample ticks |
| irq_en_i | input | 1 | Interrupt enable |
| clr_done_i | input | 1 | Clear strobe for the completion flag |
| fp_pins_i | input | 64 | Sampled levels of the frontplane pins |
| bp_pins_i | input | 64 | Sampled levels of the backplane pins |
| count_o | output | 8 | Number of asserted samples, saturating at 255 |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those where two events land on one edge: the clear strobe meeting window completion, and a start strobe arriving mid-run with every configuration input changed. The bench reaches them by numbering the run's cycles from the accepted start and firing the strobe on a computed cycle, while driving every unselected pin in both groups to the opposite level of the selected one so that a wrong mux choice or a reloaded configuration shows up in the count. Saturation is reached with long windows and the selected pin held high for exactly 254, 255 or all ticks.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

  // Default geometry shared by the block and its checker
  localparam int unsigned DEF_NUM_PINS      = 64;
  localparam int unsigned DEF_CODE_W        = 3;
  localparam int unsigned DEF_CNT_W         = 8;
  localparam int unsigned DEF_WIN_BASE_LOG2 = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/fdet_rst_sync.sv
module fdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/fdet_presc.sv
// Divides the bus clock into sample ticks, one every 2^code cycles of a run.
module fdet_presc #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned PW    = (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic [PW-1:0] limit;
  logic          at_limit;

  // limit = 2^code - 1, built as an inverted shifted mask
  always_comb begin
    limit    = ~({PW{1'b1}} << code_i);
    at_limit = (cnt_q == limit);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      if (at_limit) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = en_i & ~clear_i & at_limit;

endmodule

// File: rtl/fdet_window.sv
// Counts sample ticks and flags the tick that closes the window.
module fdet_window #(
  parameter int unsigned CODE_W        = 3,
  parameter int unsigned WIN_BASE_LOG2 = 2,
  localparam int unsigned CW           = WIN_BASE_LOG2 + (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              last_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] last_val;

  // last_val = 4*2^code - 1
  always_comb begin
    last_val = ~({CW{1'b1}} << (WIN_BASE_LOG2 + 32'(code_i)));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || tick_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = tick_i & ~clear_i & (cnt_q == last_val);

endmodule

// File: rtl/fdet_pin_mux.sv
// Picks one pin out of the frontplane or backplane group.
module fdet_pin_mux #(
  parameter int unsigned NUM_PINS = 64,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] fp_pins_i,
  input  logic [NUM_PINS-1:0] bp_pins_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                bp_sel_i,
  output logic                level_o
);

  logic [NUM_PINS-1:0] hit;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic pick;
    assign pick    = (idx_i == IDX_W'(gi));
    assign hit[gi] = pick & (bp_sel_i ? bp_pins_i[gi] : fp_pins_i[gi]);
  end

  assign level_o = |hit;

endmodule

// File: rtl/fdet_sat_cnt.sv
// Counter that clears on request and stops at its all-ones value.
module fdet_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             full;

  always_comb begin
    full  = &cnt_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (inc_i && !full) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/fdet_sample_window.sv
module fdet_sample_window
  import fdet_pkg::*;
#(
  parameter int unsigned NUM_PINS      = DEF_NUM_PINS,
  parameter int unsigned CODE_W        = DEF_CODE_W,
  parameter int unsigned CNT_W         = DEF_CNT_W,
  parameter int unsigned WIN_BASE_LOG2 = DEF_WIN_BASE_LOG2,
  localparam int unsigned IDX_W        = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    pin_idx_i,
  input  logic                bp_sel_i,
  input  logic [CODE_W-1:0]   presc_code_i,
  input  logic [CODE_W-1:0]   win_code_i,
  input  logic                irq_en_i,
  input  logic                clr_done_i,
  input  logic [NUM_PINS-1:0] fp_pins_i,
  input  logic [NUM_PINS-1:0] bp_pins_i,
  output logic [CNT_W-1:0]    count_o,
  output logic                done_o,
  output logic                irq_o
);

  logic rst_n_sync;

  run_state_e        state_q;
  run_state_e        state_d;
  logic              done_q;
  logic              done_d;
  logic [IDX_W-1:0]  idx_q;
  logic              bp_q;
  logic [CODE_W-1:0] presc_q;
  logic [CODE_W-1:0] win_q;

  logic running;
  logic start_ok;
  logic tick;
  logic win_last;
  logic pin_lvl;
  logic cnt_inc;

  fdet_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  assign running  = (state_q == ST_RUN);
  assign start_ok = start_i & ~running;

  // Next state: accept start only when idle, close on the last tick
  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    if (clr_done_i) begin
      done_d = 1'b0;
    end
    if (start_ok) begin
      state_d = ST_RUN;
      done_d  = 1'b0;
    end else if (running && win_last) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Configuration is captured only at an accepted start
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      idx_q   <= '0;
      bp_q    <= 1'b0;
      presc_q <= '0;
      win_q   <= '0;
    end else if (start_ok) begin
      idx_q   <= pin_idx_i;
      bp_q    <= bp_sel_i;
      presc_q <= presc_code_i;
      win_q   <= win_code_i;
    end
  end

  fdet_presc #(
    .CODE_W(CODE_W)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .clear_i(start_ok),
    .en_i   (running),
    .code_i (presc_q),
    .tick_o (tick)
  );

  fdet_window #(
    .CODE_W       (CODE_W),
    .WIN_BASE_LOG2(WIN_BASE_LOG2)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .clear_i(start_ok),
    .tick_i (tick),
    .code_i (win_q),
    .last_o (win_last)
  );

  fdet_pin_mux #(
    .NUM_PINS(NUM_PINS)
  ) u_mux (
    .fp_pins_i(fp_pins_i),
    .bp_pins_i(bp_pins_i),
    .idx_i    (idx_q),
    .bp_sel_i (bp_q),
    .level_o  (pin_lvl)
  );

  assign cnt_inc = tick & pin_lvl;

  fdet_sat_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .clear_i(start_ok),
    .inc_i  (cnt_inc),
    .count_o(count_o)
  );

  assign done_o = done_q;
  assign irq_o  = done_q & irq_en_i;

endmodule

// File: rtl/fdet_sample_window_chk.sv
module fdet_sample_window_chk #(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CODE_W        = 3,
  parameter int unsigned WIN_BASE_LOG2 = 2
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              start_i,
  input logic              clr_done_i,
  input logic              irq_en_i,
  input logic              running,
  input logic              done_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [CODE_W-1:0] presc_q,
  input logic [CODE_W-1:0] win_q
);

  int unsigned run_len;
  int unsigned exp_len;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
    end else if (start_i && !running) begin
      run_len <= 0;
    end else if (running) begin
      run_len <= run_len + 1;
    end
  end

  assign exp_len = 32'd1 << (WIN_BASE_LOG2 + 32'(win_q) + 32'(presc_q));

  AST_WIN_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_o) |-> (run_len == exp_len)); // R2
  AST_RUN_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    running |-> !done_o); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    running |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1))); // R3
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (running && (&count_o)) |=> (&count_o)); // R3
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !running) |=> (running && count_o == '0 && !done_o)); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && running) |=> (count_o >= $past(count_o))); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !clr_done_i && !start_i) |=> done_o); // R7
  AST_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_done_i && !running) |=> !done_o); // R7
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (done_o && irq_en_i)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!running && !start_i) |=> $stable(count_o)); // R9

endmodule

bind fdet_sample_window fdet_sample_window_chk #(
  .CNT_W        (CNT_W),
  .CODE_W       (CODE_W),
  .WIN_BASE_LOG2(WIN_BASE_LOG2)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .start_i   (start_i),
  .clr_done_i(clr_done_i),
  .irq_en_i  (irq_en_i),
  .running   (running),
  .done_o    (done_o),
  .irq_o     (irq_o),
  .count_o   (count_o),
  .presc_q   (presc_q),
  .win_q     (win_q)
);

// File: tb/tb_fdet_sample_window.sv
module tb_fdet_sample_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  pin_idx = '0;
  logic        bp_sel = 1'b0;
  logic [2:0]  presc = '0;
  logic [2:0]  win = '0;
  logic        irq_en = 1'b0;
  logic        clr = 1'b0;
  logic [63:0] fp = '0;
  logic [63:0] bp = '0;
  logic [7:0]  count;
  logic        done;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int sel_idx = 0;
  bit sel_bp = 1'b0;

  always #10 clk = ~clk;

  fdet_sample_window dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .pin_idx_i   (pin_idx),
    .bp_sel_i    (bp_sel),
    .presc_code_i(presc),
    .win_code_i  (win),
    .irq_en_i    (irq_en),
    .clr_done_i  (clr),
    .fp_pins_i   (fp),
    .bp_pins_i   (bp),
    .count_o     (count),
    .done_o      (done),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Selected pin gets l, every other pin in both groups gets !l
  task automatic drive_pins(input bit l);
    fp = {64{~l}};
    bp = {64{~l}};
    if (sel_bp) bp[sel_idx] = l;
    else        fp[sel_idx] = l;
  endtask

  function automatic int exp_cnt(input int k, input int w, input int h);
    int t;
    t = h >> k;
    if (t > (4 << w)) t = 4 << w;
    if (t > 255) t = 255;
    return t;
  endfunction

  // Runs one measurement; pin high in run cycles 1..h
  task automatic measure(input int k, input int w, input int idx, input bit b,
                         input int h, input int stray, input int clrc,
                         input bit chk_start, output int cnt, output int dur);
    int cyc;
    int lim;
    lim = ((4 << w) << k) + 2;
    @(negedge clk);
    sel_idx = idx; sel_bp = b;
    pin_idx = 6'(idx); bp_sel = b; presc = 3'(k); win = 3'(w);
    start = 1'b1;
    drive_pins(1'b0);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (chk_start) begin
      chk("R5 count cleared at start", int'(count), 0);
      chk("R5 done cleared at start", int'(done), 0);
    end
    while (!done && cyc <= lim) begin
      drive_pins(cyc <= h);
      clr = (cyc == clrc);
      if (cyc == stray) begin
        start = 1'b1; pin_idx = 6'(idx ^ 1); bp_sel = ~b; presc = '0; win = '0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    clr = 1'b0;
    dur = cyc - 1;
    cnt = int'(count);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    int d;
    irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 count in reset", int'(count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 count after reset", int'(count), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 irq after reset", int'(irq), 0);

    // R1 R2 R3: code sweep with pin held high
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < 8; w++) begin
        if (k <= 4 || w <= 2) begin
          measure(k, w, (k * 8 + w) % 64, bit'((k + w) % 2), 1 << 20, 0, 0, 1'b0, c, d);
          chk($sformatf("R2 duration k=%0d w=%0d", k, w), d, (4 << w) << k);
          chk($sformatf("R3 full count k=%0d w=%0d", k, w), c, exp_cnt(k, w, 1 << 20));
        end
      end
    end

    // R1 R3: pin high only for part of the window
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 5; w++) begin
        int h;
        h = (((4 << w) << k) / 2) + 3;
        measure(k, w, 63 - k, bit'(w % 2), h, 0, 0, 1'b0, c, d);
        chk($sformatf("R1 partial count k=%0d w=%0d", k, w), c, exp_cnt(k, w, h));
      end
    end

    // R3 saturation edges
    measure(0, 6, 7, 1'b0, 254, 0, 0, 1'b0, c, d);
    chk("R3 254 samples", c, 254);
    measure(0, 6, 7, 1'b1, 255, 0, 0, 1'b0, c, d);
    chk("R3 255 samples", c, 255);
    measure(0, 7, 9, 1'b0, 1 << 20, 0, 0, 1'b0, c, d);
    chk("R3 saturate on 512 window", c, 255);
    measure(0, 5, 9, 1'b1, 1 << 20, 0, 0, 1'b0, c, d);
    chk("R3 128 window not saturated", c, 128);

    // R4: every pin in both groups
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 64; i++) begin
        measure(0, 0, i, bit'(b), 2, 0, 0, 1'b0, c, d);
        chk($sformatf("R4 pin %0d group %0d", i, b), c, 2);
      end
    end

    // R8: interrupt follows done and enable
    chk("R8 irq with enable", int'(irq), 1);
    irq_en = 1'b0;
    #1;
    chk("R8 irq masked", int'(irq), 0);
    chk("R7 done still set", int'(done), 1);
    irq_en = 1'b1;

    // R5: start while a result is flagged
    measure(1, 1, 20, 1'b0, 9, 0, 0, 1'b1, c, d);
    chk("R5 new run count", c, 4);

    // R6: stray start with all config changed mid-run
    measure(2, 2, 12, 1'b1, 30, 10, 0, 1'b0, c, d);
    chk("R6 duration unaffected", d, 64);
    chk("R6 count unaffected", c, 7);

    // R7: clear on the completion edge loses
    measure(0, 0, 5, 1'b0, 100, 0, 4, 1'b0, c, d);
    chk("R7 set wins over clear", int'(done), 1);
    chk("R7 duration", d, 4);

    // R7 R9: clear keeps count
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R7 done cleared", int'(done), 0);
    chk("R8 irq cleared", int'(irq), 0);
    chk("R9 count held after clear", int'(count), 4);
    repeat (20) @(negedge clk);
    chk("R9 count held idle", int'(count), 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule